// File: doc/BRIEF.md
# 2B+D Serial Frame Formatter

This block carries one basic-rate ISDN payload per frame (two 8-bit bearer channels, B1 and B2, and one 2-bit signalling dibit, D) between parallel per-frame registers and a bit-serial pin pair. The block runs on the bit clock. A frame sync pulse marks the first bit of every frame. A two-bit layout select chooses one of three fixed placements of the payload inside the frame. All positions outside the active region are ignored until the next sync.

In the sequential layout, a D-port enable moves the dibit off the main pins and onto a dedicated pair of D-channel serial pins. On those pins the dibit keeps the same frame positions. Transmit words, layout and D-port choice are taken when the frame starts. The receive side captures on the falling clock edge and presents a completed frame with a one-cycle strobe.

Top module: `tbd_frame_fmt`

## Requirements
- R1: On a rising bit-clock edge where `fsync` is high, the frame bit position becomes 0. `main_tx` then carries frame bit 0 for the following clock period, and each later rising edge advances one bit position. The transmit words, `fmt_sel` and `dport_en` are all taken on that same edge.
- R2: With `fmt_sel` = 00 (code 11 behaves identically), positions 0-7 carry B1 MSB first, 8-15 carry B2 MSB first, 16 carries D[1] and 17 carries D[0].
- R3: With `fmt_sel` = 01, positions 0-7 carry B1 MSB first, 8 carries D[1], 9 is ignored, 10-17 carry B2 MSB first and 18 carries D[0].
- R4: With `fmt_sel` = 10, positions 0-7 carry B1 and 8-15 carry B2 (both MSB first), 16-23 are ignored, 24 carries D[1] and 25 carries D[0].
- R5: With `dport_en` = 1 in the R2 layout, D[1] and D[0] appear on `dch_tx` at positions 16 and 17 and are received from `dch_rx`. The main pins treat those positions as ignored. `dch_tx` is high at every other position and in every other layout, and `dport_en` has no effect in the R3 and R4 layouts.
- R6: Ignored positions, and every position after the active region until the next sync, drive `main_tx` high and leave the received words unaffected by `main_rx`.
- R7: Receive pins are sampled on the falling edge. After the last active bit of a frame is captured, `rx_b1`, `rx_b2` and `rx_d` update and `rx_valid` is high for exactly one bit-clock period, once per frame.
- R8: A frame cut short by a new sync before its last active bit produces no `rx_valid`, and the receive outputs keep their previous values.
- R9: Changes to `fmt_sel`, `dport_en` or the transmit words during a frame have no effect until the next sync.
- R10: During and after synchronous active-low reset, until the first sync, both transmit pins are high, `rx_valid` is low and the receive words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, high for one bit period at frame start |
| fmt_sel | input | 2 | Layout select (00/11 sequential, 01 split, 10 gapped) |
| dport_en | input | 1 | Route D to the dedicated pins (sequential layout) |
| tx_b1 | input | 8 | B1 word to transmit |
| tx_b2 | input | 8 | B2 word to transmit |
| tx_d | input | 2 | D dibit to transmit |
| main_tx | output | 1 | Main serial transmit pin |
| main_rx | input | 1 | Main serial receive pin |
| dch_tx | output | 1 | D-channel transmit pin |
| dch_rx | input | 1 | D-channel receive pin |
| rx_b1 | output | 8 | Received B1 word |
| rx_b2 | output | 8 | Received B2 word |
| rx_d | output | 2 | Received D dibit |
| rx_valid | output | 1 | One-period strobe when a frame has been received |

## Verification
The bench builds the block with its default parameters: 8-bit B channels and an 8-bit gap in the gapped layout. With these values every layout fits inside a 32-bit frame, which leaves at least six idle positions after each active region. That brings within reach the idle-high tail, the single strobe position one bit after the last active bit, and a sync that cuts the frame short before the gapped layout's late dibit.

// File: rtl/tbd_fmt_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the 2B+D frame formatter.
// Assumes channel widths up to 2**IDX_W bits.
package tbd_fmt_pkg;

    localparam int IDX_W = 4;

    // Frame layout codes as seen on the select port.
    typedef enum logic [1:0] {
        LAY_SEQ   = 2'b00,
        LAY_SPLIT = 2'b01,
        LAY_GAP   = 2'b10,
        LAY_ALT   = 2'b11
    } lay_e;

    // What a frame position carries on one pin pair.
    typedef enum logic [1:0] {
        SK_IDLE = 2'b00,
        SK_B1   = 2'b01,
        SK_B2   = 2'b10,
        SK_D    = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [IDX_W-1:0] idx;
    } slot_t;

endpackage

// File: rtl/tbd_frame_ctr.sv
`timescale 1ns/1ps
// Frame position counter.
// Restarts at zero on the edge where fsync is high, then counts one per bit
// clock and saturates at its all-ones value, which lies past every active
// region. Layout and D-port choice are held for the whole frame.
module tbd_frame_ctr
    import tbd_fmt_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs,
    input  lay_e             lay_in,
    input  logic             dp_in,
    output logic [CNT_W-1:0] pos_q,
    output logic [CNT_W-1:0] nxt_pos,
    output lay_e             lay_q,
    output lay_e             nxt_lay,
    output logic             dp_q,
    output logic             nxt_dp
);

    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    // Next position, layout and D-port selection.
    always_comb begin
        if (fs) begin
            nxt_pos = '0;
            nxt_lay = lay_in;
            nxt_dp  = dp_in;
        end else begin
            nxt_pos = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
            nxt_lay = lay_q;
            nxt_dp  = dp_q;
        end
    end

    // Register the frame state; reset parks the counter past all frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_MAX;
            lay_q <= LAY_SEQ;
            dp_q  <= 1'b0;
        end else begin
            pos_q <= nxt_pos;
            lay_q <= nxt_lay;
            dp_q  <= nxt_dp;
        end
    end

    AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fs |=> (pos_q == '0)); // R1

    AST_LAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fs |=> ($stable(lay_q) && $stable(dp_q))); // R9

endmodule

// File: rtl/tbd_slot_map.sv
`timescale 1ns/1ps
// Position decoder: says what a frame position carries on the main pins and
// on the D-channel pins for a given layout, and flags the last active bit.
// Purely combinational; assumes B_W <= 2**IDX_W.
module tbd_slot_map
    import tbd_fmt_pkg::*;
#(
    parameter int B_W   = 8,
    parameter int GAP_W = 8,
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] pos,
    input  lay_e             lay,
    input  logic             dp,
    output slot_t            main_slot,
    output slot_t            dch_slot,
    output logic             is_last
);

    localparam int LAST_SEQ   = 2 * B_W + 1;
    localparam int LAST_SPLIT = 2 * B_W + 2;
    localparam int LAST_GAP   = 2 * B_W + GAP_W + 1;
    localparam int D_GAP      = 2 * B_W + GAP_W;

    int p_i;
    assign p_i = int'(pos);

    function automatic slot_t mk(input kind_e k, input int ix);
        slot_t s;
        s.kind = k;
        s.idx  = IDX_W'(ix);
        return s;
    endfunction

    // Decode the position for the selected layout.
    always_comb begin
        main_slot = mk(SK_IDLE, 0);
        dch_slot  = mk(SK_IDLE, 0);
        is_last   = 1'b0;
        case (lay)
            LAY_SPLIT: begin
                if (p_i < B_W)
                    main_slot = mk(SK_B1, B_W - 1 - p_i);
                else if (p_i == B_W)
                    main_slot = mk(SK_D, 1);
                else if (p_i >= B_W + 2 && p_i < 2 * B_W + 2)
                    main_slot = mk(SK_B2, 2 * B_W + 1 - p_i);
                else if (p_i == 2 * B_W + 2)
                    main_slot = mk(SK_D, 0);
                is_last = (p_i == LAST_SPLIT);
            end
            LAY_GAP: begin
                if (p_i < B_W)
                    main_slot = mk(SK_B1, B_W - 1 - p_i);
                else if (p_i < 2 * B_W)
                    main_slot = mk(SK_B2, 2 * B_W - 1 - p_i);
                else if (p_i == D_GAP || p_i == D_GAP + 1)
                    main_slot = mk(SK_D, D_GAP + 1 - p_i);
                is_last = (p_i == LAST_GAP);
            end
            default: begin
                if (p_i < B_W)
                    main_slot = mk(SK_B1, B_W - 1 - p_i);
                else if (p_i < 2 * B_W)
                    main_slot = mk(SK_B2, 2 * B_W - 1 - p_i);
                else if (p_i == 2 * B_W || p_i == 2 * B_W + 1) begin
                    if (dp)
                        dch_slot  = mk(SK_D, 2 * B_W + 1 - p_i);
                    else
                        main_slot = mk(SK_D, 2 * B_W + 1 - p_i);
                end
                is_last = (p_i == LAST_SEQ);
            end
        endcase
    end

endmodule

// File: rtl/tbd_tx_ser.sv
`timescale 1ns/1ps
// Transmit serialiser.
// Latches the transmit words on the sync edge and drives, on each rising
// edge, the bit the slot map names for the coming position. Idle slots
// drive high. Assumes slots are decoded for the next position.
module tbd_tx_ser
    import tbd_fmt_pkg::*;
#(
    parameter int B_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fs,
    input  logic [B_W-1:0] tx_b1,
    input  logic [B_W-1:0] tx_b2,
    input  logic [1:0]     tx_d,
    input  slot_t          main_slot,
    input  slot_t          dch_slot,
    output logic           main_tx,
    output logic           dch_tx
);

    localparam int SEL_W = (B_W > 1) ? $clog2(B_W) : 1;

    logic [B_W-1:0] hb1, hb2, cb1, cb2;
    logic [1:0]     hd, cd;

    // Words used for this frame: fresh inputs on the sync edge.
    always_comb begin
        cb1 = fs ? tx_b1 : hb1;
        cb2 = fs ? tx_b2 : hb2;
        cd  = fs ? tx_d  : hd;
    end

    function automatic logic pick(input slot_t s, input logic [B_W-1:0] w1,
                                  input logic [B_W-1:0] w2, input logic [1:0] wd);
        case (s.kind)
            SK_B1:   return w1[s.idx[SEL_W-1:0]];
            SK_B2:   return w2[s.idx[SEL_W-1:0]];
            SK_D:    return wd[s.idx[0]];
            default: return 1'b1;
        endcase
    endfunction

    // Hold the frame words and register both transmit pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb1     <= '0;
            hb2     <= '0;
            hd      <= '0;
            main_tx <= 1'b1;
            dch_tx  <= 1'b1;
        end else begin
            if (fs) begin
                hb1 <= tx_b1;
                hb2 <= tx_b2;
                hd  <= tx_d;
            end
            main_tx <= pick(main_slot, cb1, cb2, cd);
            dch_tx  <= pick(dch_slot, cb1, cb2, cd);
        end
    end

endmodule

// File: rtl/tbd_rx_cap.sv
`timescale 1ns/1ps
// Receive capture.
// On each falling edge, writes the receive pin bits into the assembly words
// at the slots decoded for the current position. At the last active bit it
// copies the completed words to the outputs with a one-period strobe.
module tbd_rx_cap
    import tbd_fmt_pkg::*;
#(
    parameter int B_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  slot_t          main_slot,
    input  slot_t          dch_slot,
    input  logic           is_last,
    input  logic           main_rx,
    input  logic           dch_rx,
    output logic [B_W-1:0] rx_b1,
    output logic [B_W-1:0] rx_b2,
    output logic [1:0]     rx_d,
    output logic           rx_valid
);

    localparam int SEL_W = (B_W > 1) ? $clog2(B_W) : 1;

    logic [B_W-1:0] ab1, ab2, nb1, nb2;
    logic [1:0]     ad, nd;

    // Assembly words with this position's bit inserted.
    always_comb begin
        nb1 = ab1;
        nb2 = ab2;
        nd  = ad;
        case (main_slot.kind)
            SK_B1:   nb1[main_slot.idx[SEL_W-1:0]] = main_rx;
            SK_B2:   nb2[main_slot.idx[SEL_W-1:0]] = main_rx;
            SK_D:    nd[main_slot.idx[0]] = main_rx;
            default: ;
        endcase
        if (dch_slot.kind == SK_D)
            nd[dch_slot.idx[0]] = dch_rx;
    end

    // Capture on the falling edge and publish at the last active bit.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ab1      <= '0;
            ab2      <= '0;
            ad       <= '0;
            rx_b1    <= '0;
            rx_b2    <= '0;
            rx_d     <= '0;
            rx_valid <= 1'b0;
        end else begin
            ab1      <= nb1;
            ab2      <= nb2;
            ad       <= nd;
            rx_valid <= is_last;
            if (is_last) begin
                rx_b1 <= nb1;
                rx_b2 <= nb2;
                rx_d  <= nd;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(negedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_RX_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_b1) && $stable(rx_b2) && $stable(rx_d))); // R8

endmodule

// File: rtl/tbd_frame_fmt.sv
`timescale 1ns/1ps
// Top of the 2B+D serial frame formatter.
// Runs on the bit clock: transmit on the rising edge, receive on the
// falling edge. Assumes fsync is a single-period pulse synchronous to bclk.
module tbd_frame_fmt
    import tbd_fmt_pkg::*;
#(
    parameter int B_W   = 8,
    parameter int GAP_W = 8
) (
    input  logic           bclk,
    input  logic           rst_n,
    input  logic           fsync,
    input  logic [1:0]     fmt_sel,
    input  logic           dport_en,
    input  logic [B_W-1:0] tx_b1,
    input  logic [B_W-1:0] tx_b2,
    input  logic [1:0]     tx_d,
    output logic           main_tx,
    input  logic           main_rx,
    output logic           dch_tx,
    input  logic           dch_rx,
    output logic [B_W-1:0] rx_b1,
    output logic [B_W-1:0] rx_b2,
    output logic [1:0]     rx_d,
    output logic           rx_valid
);

    localparam int CNT_W = $clog2(2 * B_W + GAP_W + 3);

    logic [CNT_W-1:0] pos_q, nxt_pos;
    lay_e             lay_q, nxt_lay;
    logic             dp_q, nxt_dp;
    slot_t            tx_main_slot, tx_dch_slot, rx_main_slot, rx_dch_slot;
    logic             tx_last_unused, rx_last;

    tbd_frame_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk(bclk), .rst_n(rst_n), .fs(fsync),
        .lay_in(lay_e'(fmt_sel)), .dp_in(dport_en),
        .pos_q(pos_q), .nxt_pos(nxt_pos),
        .lay_q(lay_q), .nxt_lay(nxt_lay),
        .dp_q(dp_q), .nxt_dp(nxt_dp)
    );

    // Decoder for the position the transmit registers are about to present.
    tbd_slot_map #(.B_W(B_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) tx_map_i (
        .pos(nxt_pos), .lay(nxt_lay), .dp(nxt_dp),
        .main_slot(tx_main_slot), .dch_slot(tx_dch_slot), .is_last(tx_last_unused)
    );

    // Decoder for the position currently on the line.
    tbd_slot_map #(.B_W(B_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) rx_map_i (
        .pos(pos_q), .lay(lay_q), .dp(dp_q),
        .main_slot(rx_main_slot), .dch_slot(rx_dch_slot), .is_last(rx_last)
    );

    tbd_tx_ser #(.B_W(B_W)) tx_i (
        .clk(bclk), .rst_n(rst_n), .fs(fsync),
        .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_d(tx_d),
        .main_slot(tx_main_slot), .dch_slot(tx_dch_slot),
        .main_tx(main_tx), .dch_tx(dch_tx)
    );

    tbd_rx_cap #(.B_W(B_W)) rx_i (
        .clk(bclk), .rst_n(rst_n),
        .main_slot(rx_main_slot), .dch_slot(rx_dch_slot), .is_last(rx_last),
        .main_rx(main_rx), .dch_rx(dch_rx),
        .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_d(rx_d), .rx_valid(rx_valid)
    );

    AST_MAIN_IDLE_HIGH: assert property (@(posedge bclk) disable iff (!rst_n)
        (rx_main_slot.kind == SK_IDLE) |-> main_tx); // R6

    AST_DCH_IDLE_HIGH: assert property (@(posedge bclk) disable iff (!rst_n)
        (rx_dch_slot.kind == SK_IDLE) |-> dch_tx); // R5

endmodule

// File: tb/tbd_frame_fmt_tb.sv
`timescale 1ns/1ps
module tbd_frame_fmt_tb_top;

    logic       clk = 1'b0;
    logic       rst_n, fsync, dport_en, main_rx, dch_rx;
    logic [1:0] fmt_sel, tx_d;
    logic [7:0] tx_b1, tx_b2;
    logic       main_tx, dch_tx, rx_valid;
    logic [7:0] rx_b1, rx_b2;
    logic [1:0] rx_d;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    logic [7:0] e_b1 = 8'h00, e_b2 = 8'h00;
    logic [1:0] e_d  = 2'b00;

    always #2.5 clk = ~clk;

    tbd_frame_fmt dut_i (
        .bclk(clk), .rst_n(rst_n), .fsync(fsync), .fmt_sel(fmt_sel),
        .dport_en(dport_en), .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_d(tx_d),
        .main_tx(main_tx), .main_rx(main_rx), .dch_tx(dch_tx), .dch_rx(dch_rx),
        .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_d(rx_d), .rx_valid(rx_valid)
    );

    // {layout, dport, tx B1, tx B2, tx D, rx B1, rx B2, rx D}
    localparam logic [38:0] VEC [0:5] = '{
        {2'b00, 1'b0, 8'hA5, 8'h3C, 2'b10, 8'h5A, 8'hC3, 2'b01},
        {2'b00, 1'b1, 8'hF0, 8'h0F, 2'b01, 8'h81, 8'h7E, 2'b10},
        {2'b01, 1'b0, 8'h96, 8'h69, 2'b11, 8'hE7, 8'h18, 2'b10},
        {2'b01, 1'b1, 8'h12, 8'h34, 2'b10, 8'h56, 8'h78, 2'b01},
        {2'b10, 1'b0, 8'hC9, 8'h36, 2'b01, 8'h9C, 8'h63, 2'b11},
        {2'b11, 1'b0, 8'h80, 8'h01, 2'b10, 8'h00, 8'hFF, 2'b10}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected content code of a position: -1 idle, 100+i B1[i], 200+i B2[i], 300+i D[i].
    function automatic int exp_code(input logic [1:0] lay, input logic dp,
                                    input int p, input bit on_dch);
        int  c = -1;
        bit  seq = (lay == 2'b00) || (lay == 2'b11);
        if (lay == 2'b01) begin
            if (p < 8) c = 107 - p;
            else if (p == 8) c = 301;
            else if (p >= 10 && p <= 17) c = 217 - p;
            else if (p == 18) c = 300;
        end else if (lay == 2'b10) begin
            if (p < 8) c = 107 - p;
            else if (p < 16) c = 215 - p;
            else if (p == 24) c = 301;
            else if (p == 25) c = 300;
        end else begin
            if (p < 8) c = 107 - p;
            else if (p < 16) c = 215 - p;
            else if (p == 16) c = 301;
            else if (p == 17) c = 300;
        end
        if (on_dch) return (seq && dp && c >= 300) ? c : -1;
        return (seq && dp && c >= 300) ? -1 : c;
    endfunction

    function automatic logic code_bit(input int c, input logic [7:0] w1,
                                      input logic [7:0] w2, input logic [1:0] wd);
        if (c >= 300) return wd[c - 300];
        if (c >= 200) return w2[c - 200];
        if (c >= 100) return w1[c - 100];
        return 1'b1;
    endfunction

    function automatic string lay_tag(input logic [1:0] lay);
        if (lay == 2'b01) return "R3";
        if (lay == 2'b10) return "R4";
        return "R2";
    endfunction

    // One frame; called just after a rising edge. chg_at >= 0 disturbs inputs mid-frame.
    task automatic run_frame(input logic [1:0] lay, input logic dp,
                             input logic [7:0] tb1, input logic [7:0] tb2, input logic [1:0] td,
                             input logic [7:0] rb1, input logic [7:0] rb2, input logic [1:0] rd,
                             input int flen, input int chg_at);
        int  last = (lay == 2'b01) ? 18 : (lay == 2'b10) ? 25 : 17;
        int  nval = 0;
        bit  dmode = ((lay == 2'b00) || (lay == 2'b11)) && dp;
        fmt_sel = lay; dport_en = dp; tx_b1 = tb1; tx_b2 = tb2; tx_d = td;
        fsync = 1'b1;
        for (int p = 0; p < flen; p++) begin
            int    cm, cd;
            string tg;
            @(posedge clk);
            #1;
            fsync = 1'b0;
            if (p == chg_at) begin
                fmt_sel  = (lay == 2'b10) ? 2'b01 : 2'b10;
                dport_en = ~dp;
                tx_b1 = ~tb1; tx_b2 = ~tb2; tx_d = ~td;
            end
            cm = exp_code(lay, dp, p, 1'b0);
            cd = exp_code(lay, dp, p, 1'b1);
            if (cm >= 0) main_rx = code_bit(cm, rb1, rb2, rd);
            else if (dmode && cd >= 0) main_rx = ~code_bit(cd, rb1, rb2, rd);
            else main_rx = p[0];
            dch_rx = (cd >= 0) ? code_bit(cd, rb1, rb2, rd) : ~p[0];
            #1;
            tg = (chg_at >= 0 && p > chg_at) ? "R9" : (cm < 0) ? "R6" : lay_tag(lay);
            chk(main_tx === code_bit(cm, tb1, tb2, td), tg, $sformatf("main_tx pos %0d", p),
                int'(main_tx), int'(code_bit(cm, tb1, tb2, td)));
            chk(dch_tx === code_bit(cd, tb1, tb2, td), "R5", $sformatf("dch_tx pos %0d", p),
                int'(dch_tx), int'(code_bit(cd, tb1, tb2, td)));
            if (rx_valid === 1'b1) begin
                nval++;
                chk(p == last + 1, "R7", "rx_valid position", p, last + 1);
            end
        end
        if (flen >= last + 2) begin
            e_b1 = rb1; e_b2 = rb2; e_d = rd;
            chk(nval == 1, "R7", "rx_valid count", nval, 1);
            chk(rx_b1 === e_b1, "R7", "rx_b1", int'(rx_b1), int'(e_b1));
            chk(rx_b2 === e_b2, "R7", "rx_b2", int'(rx_b2), int'(e_b2));
            chk(rx_d === e_d, dmode ? "R5" : "R7", "rx_d", int'(rx_d), int'(e_d));
        end else begin
            chk(nval == 0, "R8", "rx_valid count short", nval, 0);
            chk(rx_b1 === e_b1, "R8", "rx_b1 kept", int'(rx_b1), int'(e_b1));
            chk(rx_b2 === e_b2, "R8", "rx_b2 kept", int'(rx_b2), int'(e_b2));
            chk(rx_d === e_d, "R8", "rx_d kept", int'(rx_d), int'(e_d));
        end
    endtask

    initial begin
        rst_n = 1'b0; fsync = 1'b0; fmt_sel = 2'b00; dport_en = 1'b0;
        tx_b1 = 8'h00; tx_b2 = 8'h00; tx_d = 2'b00; main_rx = 1'b1; dch_rx = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R10: state under reset
        chk(main_tx === 1'b1, "R10", "main_tx in reset", int'(main_tx), 1);
        chk(dch_tx === 1'b1, "R10", "dch_tx in reset", int'(dch_tx), 1);
        chk(rx_valid === 1'b0, "R10", "rx_valid in reset", int'(rx_valid), 0);
        chk(rx_b1 === 8'h00 && rx_b2 === 8'h00 && rx_d === 2'b00, "R10", "rx words in reset",
            int'({rx_b1, rx_b2, rx_d}), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        tx_b1 = 8'h00; tx_b2 = 8'h00; tx_d = 2'b00; main_rx = 1'b0; dch_rx = 1'b0;
        // R10: no frame before the first sync
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            #2;
            chk(main_tx === 1'b1 && dch_tx === 1'b1, "R10", "pins idle before sync",
                int'({main_tx, dch_tx}), 3);
            chk(rx_valid === 1'b0, "R10", "no strobe before sync", int'(rx_valid), 0);
        end
        // Vector table walk (R2, R3, R4, R5, R6, R7)
        for (int v = 0; v < 6; v++) begin
            logic [38:0] t = VEC[v];
            run_frame(t[38:37], t[36], t[35:28], t[27:20], t[19:18],
                      t[17:10], t[9:2], t[1:0], 32, -1);
        end
        // R9: layout, D-port and transmit words disturbed mid-frame
        run_frame(2'b00, 1'b1, 8'h5C, 8'hE1, 2'b01, 8'h3A, 8'hB4, 2'b11, 32, 5);
        run_frame(2'b10, 1'b0, 8'h71, 8'h8E, 2'b10, 8'h0F, 8'hF0, 2'b01, 32, 20);
        // R8: gapped frame cut short before its dibit, then a full frame
        run_frame(2'b10, 1'b0, 8'hAA, 8'h55, 2'b11, 8'h11, 8'h22, 2'b00, 20, -1);
        run_frame(2'b01, 1'b0, 8'h3E, 8'hC1, 2'b01, 8'hDB, 8'h24, 2'b01, 32, -1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule